// File: doc/BRIEF.md
# Late-Arrival Detecting Product Register

This block is the output register bank of a variable-latency multiplier. It holds one guarded bit for each of the 2m product bits of an m-by-m array. Each bit keeps two copies of the same combinational result. The main copy is taken on the normal clock. The shadow copy is taken on a second clock input that rises a fixed phase later within the same cycle. If the two copies differ, the result arrived after the normal edge. The main copy is then wrong, and the bank replaces it with the shadow copy.

The bank sends one error flag to the latency controller and to the rest of the system, which re-issues the operation with a longer latency. A comparison is made only for cycles in which the capture enable was high. While the bank is idle or holding, the flag stays low. When a mismatch is found, the correction has priority at that edge, and any new capture requested at the same edge is dropped. The system re-issues that operation. The phase-lagged clock is an input to the block; this block does not generate it.

Top module: `tg_product_bank`

## Requirements
- R1: While rst_ni is low, and after it is released, q_o is 0 and err_o is 0.
- R2: When cap_en_i is 1 at a rising edge of clk_i and no mismatch is pending, q_o takes the value of d_i present at that edge.
- R3: When cap_en_i is 0 at a rising edge of clk_i, q_o keeps its value. At the following edge no error is raised for that cycle.
- R4: On every rising edge of clk_late_i, the shadow copy samples d_i. A change on d_i after the clk_i edge but before the clk_late_i edge therefore reaches the shadow copy only.
- R5: After a capture edge, the main copy is compared with the shadow sample taken at the next clk_late_i edge. At the next clk_i edge, err_o becomes 1 if any bit differs and stays 0 if none differ. err_o is registered and lasts one cycle.
- R6: At the clk_i edge where a mismatch is found, q_o loads the shadow copy. The corrected product appears in the same cycle in which err_o is 1.
- R7: The flag is the OR of all per-bit mismatches. A difference in bit 0 alone, or in the top bit alone, raises err_o.
- R8: A capture requested at the correction edge is discarded and is not compared. q_o keeps the corrected value, and err_o is 0 in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Normal clock; main copies sample on its rising edge |
| clk_late_i | input | 1 | Phase-lagged clock; shadow copies sample on its rising edge |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cap_en_i | input | 1 | Capture enable for the current cycle |
| d_i | input | 2*OPW | Product from the multiplier array |
| q_o | output | 2*OPW | Registered, corrected product |
| err_o | output | 1 | Late-arrival flag, one cycle, registered |

## Verification
The risk is a stuck or stale main or shadow bit, or a wrongly qualified compare. At the ports this would show as a false or missing err_o, or a wrong q_o, exactly one clk_i cycle after the capture that caused it. For this reason every vector is sampled one edge after its capture. Late transitions are injected between the two clock edges, with single-bit differences at both ends of the word. The dropped capture on a correction edge is checked by holding q_o for one more cycle.

// File: rtl/tg_pkg.sv
package tg_pkg;
  localparam int unsigned TG_OPW_DEF = 16;

  function automatic int unsigned tg_pow2_ceil(input int unsigned n);
    int unsigned p;
    p = 1;
    while (p < n) p = p << 1;
    return p;
  endfunction
endpackage

// File: rtl/tg_guard_bit.sv
module tg_guard_bit (
  input  logic clk_i,
  input  logic clk_late_i,
  input  logic rst_ni,
  input  logic cap_i,
  input  logic chk_i,
  input  logic fix_i,
  input  logic d_i,
  output logic q_o,
  output logic mis_o
);
  logic main_q;
  logic shadow_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    main_q <= 1'b0;
    else if (fix_i) main_q <= shadow_q;
    else if (cap_i) main_q <= d_i;
  end

  always_ff @(posedge clk_late_i or negedge rst_ni) begin
    if (!rst_ni) shadow_q <= 1'b0;
    else         shadow_q <= d_i;
  end

  assign mis_o = chk_i & (main_q ^ shadow_q);
  assign q_o   = main_q;

  p_capture_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cap_i && !fix_i) |=> (q_o == $past(d_i)));
  p_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cap_i && !fix_i) |=> $stable(q_o));
  p_restore_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fix_i |=> (q_o == $past(shadow_q)));
endmodule

// File: rtl/tg_or_tree.sv
module tg_or_tree #(
  parameter int unsigned N = 32
) (
  input  logic [N-1:0] in_i,
  output logic         any_o
);
  localparam int unsigned P = tg_pkg::tg_pow2_ceil(N);
  localparam int unsigned NODES = 2 * P - 1;

  logic [NODES-1:0] node;

  for (genvar i = 0; i < P; i++) begin : g_leaf
    if (i < N) begin : g_used
      assign node[P-1+i] = in_i[i];
    end else begin : g_pad
      assign node[P-1+i] = 1'b0;
    end
  end

  for (genvar k = 0; k < P - 1; k++) begin : g_node
    assign node[k] = node[2*k+1] | node[2*k+2];
  end

  assign any_o = node[0];

  always_comb begin
    assert (any_o == (|in_i)) else $error("or tree mismatch r7");
  end
endmodule

// File: rtl/tg_product_bank.sv
module tg_product_bank #(
  parameter int unsigned OPW = tg_pkg::TG_OPW_DEF
) (
  input  logic             clk_i,
  input  logic             clk_late_i,
  input  logic             rst_ni,
  input  logic             cap_en_i,
  input  logic [2*OPW-1:0] d_i,
  output logic [2*OPW-1:0] q_o,
  output logic             err_o
);
  localparam int unsigned W = 2 * OPW;

  logic         chk_q;
  logic         err_q;
  logic         fix;
  logic         cap;
  logic [W-1:0] mis;

  // correction wins; a capture on a correction edge is dropped
  assign cap = cap_en_i & ~fix;

  for (genvar b = 0; b < W; b++) begin : g_bit
    tg_guard_bit u_bit (
      .clk_i      (clk_i),
      .clk_late_i (clk_late_i),
      .rst_ni     (rst_ni),
      .cap_i      (cap),
      .chk_i      (chk_q),
      .fix_i      (fix),
      .d_i        (d_i[b]),
      .q_o        (q_o[b]),
      .mis_o      (mis[b])
    );
  end

  tg_or_tree #(.N(W)) u_or (
    .in_i  (mis),
    .any_o (fix)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      chk_q <= 1'b0;
      err_q <= 1'b0;
    end else begin
      chk_q <= cap;
      err_q <= fix;
    end
  end

  assign err_o = err_q;

  p_err_needs_cap_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> $past(cap_en_i, 2));
  p_err_single_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |=> !err_o);
  p_idle_quiet_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(cap_en_i) |-> !fix);
endmodule

// File: tb/tg_product_bank_tb_top.sv
module tg_product_bank_tb_top;
  localparam int unsigned OPW = 16;
  localparam int unsigned W = 2 * OPW;
  localparam time CLK_PERIOD = 10;
  localparam time LATE_LAG = 4;
  localparam int NV = 9;

  // capture data, data after late transition, enable
  localparam logic [W-1:0] V_D [NV] = '{
    32'h0000_1234, 32'hDEAD_BEEF, 32'hFFFF_FFFF, 32'h0F0F_0F0F, 32'h8000_0000,
    32'h1357_9BDF, 32'hAAAA_5555, 32'h0000_0000, 32'h7FFF_FFFF};
  localparam logic [W-1:0] V_L [NV] = '{
    32'h0000_1234, 32'hDEAD_BEEF, 32'hFFFF_FFFE, 32'h8F0F_0F0F, 32'h8000_0000,
    32'h2468_ACE0, 32'hAAAA_5555, 32'h0000_0001, 32'hFFFF_FFFF};
  localparam logic V_E [NV] = '{1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1};

  logic clk = 1'b0;
  logic clk_late;
  logic rst_n = 1'b0;
  logic cap_en = 1'b0;
  logic [W-1:0] d = '0;
  logic [W-1:0] q;
  logic err;
  logic [W-1:0] q_exp = '0;
  int n_chk = 0;
  int n_err = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;
  assign #(LATE_LAG) clk_late = clk;

  tg_product_bank #(.OPW(OPW)) dut_i (
    .clk_i      (clk),
    .clk_late_i (clk_late),
    .rst_ni     (rst_n),
    .cap_en_i   (cap_en),
    .d_i        (d),
    .q_o        (q),
    .err_o      (err)
  );

  task automatic check(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // capture at one edge, late change before the shadow edge, sample after the next edge
  task automatic run_vec(input logic [W-1:0] dv, input logic [W-1:0] lv, input logic en, input string tag);
    logic mm;
    @(negedge clk);
    d = dv;
    cap_en = en;
    @(posedge clk);
    #2 d = lv;
    @(negedge clk);
    cap_en = 1'b0;
    @(posedge clk);
    #1;
    mm = en && (dv != lv);
    if (en) q_exp = lv;
    check({tag, " q"}, q, q_exp);
    check({tag, " err"}, {{(W-1){1'b0}}, err}, {{(W-1){1'b0}}, mm});
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_err++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk + 1);
    $finish;
  end

  initial begin
    #3;
    check("R1 q in reset", q, '0);
    check("R1 err in reset", {{(W-1){1'b0}}, err}, '0);
    #(CLK_PERIOD * 2);
    rst_n = 1'b1;
    @(posedge clk);
    #1;
    check("R1 q after release", q, '0);
    check("R1 err after release", {{(W-1){1'b0}}, err}, '0);

    // R2 R3 R4 R5 R6 R7 via table
    for (int i = 0; i < NV; i++) begin
      run_vec(V_D[i], V_L[i], V_E[i], $sformatf("R2/R5/R7 vec%0d", i));
    end

    // R3: idle with late-changing data raises nothing and holds q
    run_vec(32'h1111_1111, 32'h2222_2222, 1'b0, "R3 idle");

    // R6 R8: capture requested at the correction edge is dropped
    @(negedge clk);
    d = 32'h0000_00F0;
    cap_en = 1'b1;
    @(posedge clk);
    #2 d = 32'h0000_00F1;
    @(negedge clk);
    d = 32'h5A5A_5A5A;
    cap_en = 1'b1;
    @(posedge clk);
    #1;
    check("R6 corrected q", q, 32'h0000_00F1);
    check("R6 err", {{(W-1){1'b0}}, err}, 1);
    @(negedge clk);
    cap_en = 1'b0;
    @(posedge clk);
    #1;
    check("R8 dropped capture q", q, 32'h0000_00F1);
    check("R8 err low", {{(W-1){1'b0}}, err}, 0);

    // R4: clean capture after the shadow resynchronises
    run_vec(32'hCAFE_0001, 32'hCAFE_0001, 1'b1, "R4 clean");

    // R1: asynchronous reset mid-run
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    check("R1 async q", q, '0);
    check("R1 async err", {{(W-1){1'b0}}, err}, '0);

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule